// File: doc/BRIEF.md
# Status register update unit

This block holds the 64-bit processor status word of a core and applies at most one decoded status-register operation per clock. The decode stage presents an operation code, a 24-bit immediate, a general-register source value and the saved status used when returning from an interrupt, together with a valid strobe. The block updates the word on the following clock edge. For the two read operations it places a masked copy of the word on a registered result bus.

Operations fall into two groups. User-mask operations and the reads are allowed at every privilege level. The remaining operations are privileged: system-mask set and clear, the lower-half load, the bank and machine-mode switches, and the full restore. The current privilege level sits in bits 33:32 of the word. A privileged operation issued while that field is nonzero is refused, and a one-cycle fault pulse is raised.

Two states drive the fault output. ST_RUN is the normal state. The transition RUN_TO_FAULT is taken on a refused operation. ST_FAULT drives the fault flag for that cycle. From ST_FAULT the transition FAULT_TO_RUN is taken unless another refused operation arrives, in which case FAULT_TO_FAULT keeps the flag high.

Top module: `stat_word_unit`

## Requirements
- R1: A synchronous reset clears the status word, the read result and the fault flag to zero.
- R2: Opcode 1 ORs op_imm[5:0] into bits 5:0, and opcode 2 clears every bit 5:0 whose op_imm bit is set. Both are allowed at every privilege level, and the other bits do not change.
- R3: Opcode 3 loads bits 5:0 from gr_src[5:0] and leaves all other bits unchanged.
- R4: Opcode 5 ORs op_imm into bits 23:0, and opcode 6 clears bits 23:0 wherever op_imm is set.
- R5: Opcode 7 replaces bits 31:0 with gr_src[31:0] and leaves bits 63:32 unchanged.
- R6: Read results appear on read_data one edge after the read and hold until the next read. Opcode 4 returns bits 5:0 zero-extended. Opcode 8 returns bits 36:35 and 31:0 in place, with every other bit zero. Neither read changes the word.
- R7: Opcodes 9 and 10 write 0 and 1 to bit 44. Opcodes 11 and 12 write 0 and 1 to bit 46.
- R8: Opcode 13 loads the word from saved_word.
- R9: Reserved bits 6 to 12, 16, 28 to 31 and 47 to 63 are written as zero by every update.
- R10: Opcodes 5, 6, 7 and 9 to 13, issued while bits 33:32 are nonzero, leave the word unchanged and raise priv_fault for exactly the next cycle. No other case raises it.
- R11: With op_valid low, or with opcode 0, 14 or 15, the word and read_data do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Decoded operation code |
| op_imm | input | 24 | Immediate operand |
| gr_src | input | 64 | General-register source value |
| saved_word | input | 64 | Saved status used by the restore operation |
| status_word | output | 64 | Current status word |
| read_data | output | 64 | Registered masked read result |
| priv_fault | output | 1 | One-cycle privilege fault pulse |

## Verification
On every cycle the assertions check the following: reserved bits stay zero, idle cycles leave the outputs alone, a refused operation holds the word and pulses the fault, the upper half survives a lower-half load, and read results carry no bits outside their window. Some behaviour shows only through the bench scenarios. These include the exact values after mixed set, clear and load sequences, and the masking of a restore from an all-ones saved value. They also include user-mask operations succeeding at a nonzero privilege, back-to-back faults, and a second reset from a privileged state.

// File: rtl/stat_word_pkg.sv
package stat_word_pkg;

    localparam int SW_W     = 64;
    localparam int IMM_W    = 24;
    localparam int UM_W     = 6;
    localparam int SM_W     = 24;
    localparam int LOW_W    = 32;
    localparam int PRIV_LO  = 32;
    localparam int PRIV_HI  = 33;
    localparam int BANK_BIT = 44;
    localparam int VM_BIT   = 46;

    typedef enum logic [3:0] {
        OP_NOP       = 4'd0,
        OP_UM_SET    = 4'd1,
        OP_UM_CLR    = 4'd2,
        OP_UM_LOAD   = 4'd3,
        OP_UM_READ   = 4'd4,
        OP_SM_SET    = 4'd5,
        OP_SM_CLR    = 4'd6,
        OP_LOW_LOAD  = 4'd7,
        OP_FULL_READ = 4'd8,
        OP_BANK_OFF  = 4'd9,
        OP_BANK_ON   = 4'd10,
        OP_VM_OFF    = 4'd11,
        OP_VM_ON     = 4'd12,
        OP_RESTORE   = 4'd13
    } stat_op_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_FAULT = 1'b1
    } fault_state_e;

    function automatic logic [SW_W-1:0] f_rsv_mask();
        logic [SW_W-1:0] m;
        m = '0;
        for (int i = 0; i < SW_W; i++) begin
            if ((i >= 6 && i <= 12) || i == 16 || (i >= 28 && i <= 31) || i >= 47)
                m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [SW_W-1:0] f_read_mask();
        logic [SW_W-1:0] m;
        m = '0;
        for (int i = 0; i < SW_W; i++) begin
            if (i < LOW_W || i == 35 || i == 36)
                m[i] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [SW_W-1:0] RSV_MASK  = f_rsv_mask();
    localparam logic [SW_W-1:0] READ_MASK = f_read_mask();

endpackage

// File: rtl/stat_priv_gate.sv
module stat_priv_gate
    import stat_word_pkg::*;
#(
    parameter int W = SW_W
) (
    input  logic           valid,
    input  stat_op_e       op,
    input  logic [W-1:0]   cur,
    output logic           fault_req,
    output logic           commit
);

    logic is_priv;
    logic is_write;
    logic priv_nonzero;

    always_comb begin
        is_priv  = op inside {OP_SM_SET, OP_SM_CLR, OP_LOW_LOAD, OP_BANK_OFF,
                              OP_BANK_ON, OP_VM_OFF, OP_VM_ON, OP_RESTORE};
        is_write = is_priv || (op inside {OP_UM_SET, OP_UM_CLR, OP_UM_LOAD});
    end

    assign priv_nonzero = |cur[PRIV_HI:PRIV_LO];
    assign fault_req    = valid && is_priv && priv_nonzero;
    assign commit       = valid && is_write && !fault_req;

endmodule

// File: rtl/stat_next_calc.sv
module stat_next_calc
    import stat_word_pkg::*;
#(
    parameter int W = SW_W
) (
    input  stat_op_e         op,
    input  logic [W-1:0]     cur,
    input  logic [IMM_W-1:0] imm,
    input  logic [W-1:0]     gr,
    input  logic [W-1:0]     saved,
    output logic [W-1:0]     nxt
);

    logic [W-1:0] raw;

    always_comb begin
        raw = cur;
        unique case (op)
            OP_UM_SET:   raw[UM_W-1:0]  = cur[UM_W-1:0] | imm[UM_W-1:0];
            OP_UM_CLR:   raw[UM_W-1:0]  = cur[UM_W-1:0] & ~imm[UM_W-1:0];
            OP_UM_LOAD:  raw[UM_W-1:0]  = gr[UM_W-1:0];
            OP_SM_SET:   raw[SM_W-1:0]  = cur[SM_W-1:0] | imm[SM_W-1:0];
            OP_SM_CLR:   raw[SM_W-1:0]  = cur[SM_W-1:0] & ~imm[SM_W-1:0];
            OP_LOW_LOAD: raw[LOW_W-1:0] = gr[LOW_W-1:0];
            OP_BANK_OFF: raw[BANK_BIT]  = 1'b0;
            OP_BANK_ON:  raw[BANK_BIT]  = 1'b1;
            OP_VM_OFF:   raw[VM_BIT]    = 1'b0;
            OP_VM_ON:    raw[VM_BIT]    = 1'b1;
            OP_RESTORE:  raw            = saved;
            default:     raw            = cur;
        endcase
    end

    assign nxt = raw & ~RSV_MASK;

endmodule

// File: rtl/stat_read_sel.sv
module stat_read_sel
    import stat_word_pkg::*;
#(
    parameter int W = SW_W
) (
    input  logic           valid,
    input  stat_op_e       op,
    input  logic [W-1:0]   cur,
    output logic           rd_load,
    output logic [W-1:0]   rd_value
);

    always_comb begin
        rd_load  = 1'b0;
        rd_value = '0;
        if (valid) begin
            unique case (op)
                OP_UM_READ: begin
                    rd_load  = 1'b1;
                    rd_value = {{(W-UM_W){1'b0}}, cur[UM_W-1:0]};
                end
                OP_FULL_READ: begin
                    rd_load  = 1'b1;
                    rd_value = cur & READ_MASK;
                end
                default: begin
                    rd_load  = 1'b0;
                    rd_value = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/stat_word_unit.sv
module stat_word_unit
    import stat_word_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [IMM_W-1:0]  op_imm,
    input  logic [SW_W-1:0]   gr_src,
    input  logic [SW_W-1:0]   saved_word,
    output logic [SW_W-1:0]   status_word,
    output logic [SW_W-1:0]   read_data,
    output logic              priv_fault
);

    stat_op_e     op;
    logic         fault_req;
    logic         commit;
    logic         rd_load;
    logic [SW_W-1:0] nxt_word;
    logic [SW_W-1:0] rd_value;
    logic [SW_W-1:0] word_q;
    logic [SW_W-1:0] rd_q;
    fault_state_e state_q;
    fault_state_e state_d;

    assign op = stat_op_e'(op_code);

    stat_priv_gate #(.W(SW_W)) u_gate (
        .valid     (op_valid),
        .op        (op),
        .cur       (word_q),
        .fault_req (fault_req),
        .commit    (commit)
    );

    stat_next_calc #(.W(SW_W)) u_calc (
        .op    (op),
        .cur   (word_q),
        .imm   (op_imm),
        .gr    (gr_src),
        .saved (saved_word),
        .nxt   (nxt_word)
    );

    stat_read_sel #(.W(SW_W)) u_read (
        .valid    (op_valid),
        .op       (op),
        .cur      (word_q),
        .rd_load  (rd_load),
        .rd_value (rd_value)
    );

    // Fault state: RUN_TO_FAULT, FAULT_TO_FAULT, FAULT_TO_RUN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   state_d = fault_req ? ST_FAULT : ST_RUN;
            ST_FAULT: state_d = fault_req ? ST_FAULT : ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            rd_q   <= '0;
        end else begin
            if (commit)  word_q <= nxt_word;
            if (rd_load) rd_q   <= rd_value;
        end
    end

    always_comb begin
        status_word = word_q;
        read_data   = rd_q;
        priv_fault  = (state_q == ST_FAULT);
    end

endmodule

// File: rtl/stat_word_chk.sv
module stat_word_chk
    import stat_word_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [3:0]        op_code,
    input logic [IMM_W-1:0]  op_imm,
    input logic [SW_W-1:0]   saved_word,
    input logic [SW_W-1:0]   status_word,
    input logic [SW_W-1:0]   read_data,
    input logic              priv_fault
);

    logic priv_op;
    logic at_user;
    assign priv_op = (op_code inside {4'd5, 4'd6, 4'd7, 4'd9, 4'd10, 4'd11, 4'd12, 4'd13});
    assign at_user = (status_word[PRIV_HI:PRIV_LO] == 2'b00);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (status_word == '0 && read_data == '0 && !priv_fault)); // R1

    AST_UM_SET_OR: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 4'd1) |=>
        status_word[5:0] == ($past(status_word[5:0]) | $past(op_imm[5:0]))); // R2

    AST_LOW_KEEPS_HIGH: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 4'd7) |=>
        status_word[63:32] == $past(status_word[63:32])); // R5

    AST_READ_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 4'd8) |=> ((read_data & ~READ_MASK) == '0)); // R6

    AST_BANK_ON: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 4'd10 && at_user) |=> status_word[BANK_BIT]); // R7

    AST_RESTORE_LOAD: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 4'd13 && at_user) |=>
        status_word == ($past(saved_word) & ~RSV_MASK)); // R8

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        (status_word & RSV_MASK) == '0); // R9

    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op_valid && priv_op && !at_user) |=>
        (priv_fault && status_word == $past(status_word))); // R10

    AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        !(op_valid && priv_op && !at_user) |=> !priv_fault); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (status_word == $past(status_word) &&
                       read_data == $past(read_data))); // R11

endmodule

bind stat_word_unit stat_word_chk u_chk (.*);

// File: tb/stat_word_unit_test.sv
module stat_word_unit_test;

    localparam logic [63:0] T_RSV  = 64'hFFFF_8000_F001_1FC0;
    localparam logic [63:0] T_READ = 64'h0000_0018_FFFF_FFFF;

    typedef struct {
        logic [63:0] psw;
        logic [63:0] rd;
        logic        flt;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [23:0] op_imm = '0;
    logic [63:0] gr_src = '0;
    logic [63:0] saved_word = '0;
    logic [63:0] status_word;
    logic [63:0] read_data;
    logic        priv_fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    exp_t q[$];
    logic [63:0] m_psw = '0;
    logic [63:0] m_rd  = '0;

    always #10 clk = ~clk;

    stat_word_unit uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .op_imm(op_imm), .gr_src(gr_src), .saved_word(saved_word),
        .status_word(status_word), .read_data(read_data), .priv_fault(priv_fault)
    );

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: one operation per cycle, expected result pushed to the scoreboard
    task automatic issue(input bit v, input logic [3:0] op, input logic [23:0] imm,
                         input logic [63:0] gr, input logic [63:0] sv, input string tag);
        exp_t e;
        logic [63:0] n;
        bit priv_op, flt;
        @(negedge clk);
        op_valid = v; op_code = op; op_imm = imm; gr_src = gr; saved_word = sv;
        priv_op = (op == 5 || op == 6 || op == 7 || (op >= 9 && op <= 13));
        flt = v && priv_op && (m_psw[33:32] != 2'b00);
        n = m_psw;
        if (v && !flt) begin
            case (op)
                1:  n[5:0]  = m_psw[5:0] | imm[5:0];
                2:  n[5:0]  = m_psw[5:0] & ~imm[5:0];
                3:  n[5:0]  = gr[5:0];
                4:  m_rd    = {58'b0, m_psw[5:0]};
                5:  n[23:0] = m_psw[23:0] | imm;
                6:  n[23:0] = m_psw[23:0] & ~imm;
                7:  n[31:0] = gr[31:0];
                8:  m_rd    = m_psw & T_READ;
                9:  n[44]   = 1'b0;
                10: n[44]   = 1'b1;
                11: n[46]   = 1'b0;
                12: n[46]   = 1'b1;
                13: n       = sv;
                default: ;
            endcase
        end else if (v && (op == 4 || op == 8)) begin
            m_rd = (op == 4) ? {58'b0, m_psw[5:0]} : (m_psw & T_READ);
        end
        m_psw = n & ~T_RSV;
        e.psw = m_psw; e.rd = m_rd; e.flt = flt; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compares each result one edge after its operation
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(e.tag, "status_word", status_word, e.psw);
            check(e.tag, "read_data", read_data, e.rd);
            check(e.tag, "priv_fault", {63'b0, priv_fault}, {63'b0, e.flt});
        end
    end

    task automatic do_reset();
        @(negedge clk);
        op_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_psw = '0;
        m_rd  = '0;
        check("R1", "status_word", status_word, 64'h0);
        check("R1", "read_data", read_data, 64'h0);
        check("R1", "priv_fault", {63'b0, priv_fault}, 64'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R2: only bits 5:0 take the immediate
        issue(1, 4'd1, 24'hFFFF_FF, '0, '0, "R2");
        issue(1, 4'd2, 24'h000005, '0, '0, "R2");
        // R3
        issue(1, 4'd3, '0, 64'hFFFF_FFFF_FFFF_FFFF, '0, "R3");
        issue(1, 4'd3, '0, 64'h0000_0000_0000_0052, '0, "R3");
        issue(1, 4'd4, '0, '0, '0, "R6");
        // R4 and R9
        issue(1, 4'd5, 24'hFFFFFF, '0, '0, "R4_R9");
        issue(1, 4'd6, 24'h000F0F, '0, '0, "R4");
        // R5
        issue(1, 4'd7, '0, 64'hFFFF_FFFF_1234_5678, '0, "R5");
        issue(1, 4'd8, '0, '0, '0, "R6");
        // R7
        issue(1, 4'd10, '0, '0, '0, "R7");
        issue(1, 4'd12, '0, '0, '0, "R7");
        issue(1, 4'd9, '0, '0, '0, "R7");
        // R8 and R9: all-ones restore at privilege 0
        issue(1, 4'd13, '0, '0, 64'hFFFF_FFFC_FFFF_FFFF, "R8_R9");
        issue(1, 4'd8, '0, '0, '0, "R6");
        issue(1, 4'd11, '0, '0, '0, "R7");
        issue(1, 4'd4, '0, '0, '0, "R6");
        // R11: idle strobe and unused opcodes
        issue(0, 4'd13, 24'hFFFFFF, 64'h0, 64'h0, "R11");
        issue(0, 4'd8, '0, '0, '0, "R11");
        issue(1, 4'd0, 24'hFFFFFF, 64'h0, 64'h0, "R11");
        issue(1, 4'd14, 24'hFFFFFF, 64'h0, 64'h0, "R11");
        issue(1, 4'd15, 24'hFFFFFF, 64'h0, 64'h0, "R11");
        // R10: enter privilege 2, then refused operations
        issue(1, 4'd13, '0, '0, 64'h0000_0002_0000_00AA, "R8");
        issue(1, 4'd5, 24'hFFFFFF, '0, '0, "R10");
        issue(1, 4'd0, '0, '0, '0, "R10");
        issue(1, 4'd7, '0, 64'hFFFF_FFFF_FFFF_FFFF, '0, "R10");
        issue(1, 4'd10, '0, '0, '0, "R10");
        issue(1, 4'd13, '0, '0, 64'h0, "R10");
        issue(1, 4'd6, 24'hFFFFFF, '0, '0, "R10");
        issue(1, 4'd1, 24'h000005, '0, '0, "R2");
        issue(1, 4'd2, 24'h000020, '0, '0, "R2");
        issue(1, 4'd8, '0, '0, '0, "R6");
        issue(0, 4'd0, '0, '0, '0, "R10");
        @(posedge clk); #2;
        do_reset();
        issue(1, 4'd8, '0, '0, '0, "R6");
        @(posedge clk); #2;
        finish_run();
    end

endmodule